// File: doc/BRIEF.md
# CPU-to-Microcontroller Byte Mailbox with SPI Slave

This block lets a Z80-style CPU and an external microcontroller swap one byte per exchange. The CPU writes a byte to the mailbox data port. The block latches that byte and drives an active-low request line. The microcontroller sees the request and, as SPI master, clocks one 8-bit frame. During that frame the outgoing byte shifts out on MISO and the reply shifts in from MOSI. The microcontroller then pulls the active-low acknowledge line low briefly, which clears the request. The CPU polls the status port until the busy flag drops, then reads the reply from the data port.

The SPI pins and the acknowledge line are asynchronous to the block. Each one passes through a two-flop synchronizer into the system clock, so the SPI rate has to stay well below the system clock. The status port also reports the video sync levels, so one poll loop can wait on either the mailbox or the raster.

Top module: `spi_mbx`

## Requirements
- R1: After reset, `req_no` is 1, the receive buffer reads 0x00 and the status busy flag (bit 0) is 0.
- R2: A write to the data port (default address 0xFB) while idle latches `io_wdata_i` as the transmit byte and drives `req_no` low from the next clock edge.
- R3: A write to the data port while the request is still pending is ignored: the byte shifted out on MISO is still the first byte written.
- R4: SPI is mode 0 and MSB first. MISO presents transmit bit 7 before the first rising SCK edge and moves to the next bit after each falling edge. MOSI is sampled on rising edges, and the first bit sampled becomes bit 7 of the reply.
- R5: The receive buffer changes only when a full 8-bit frame has been clocked. If chip select rises after fewer than 8 bits, the buffer keeps its previous value.
- R6: A falling edge on `ack_ni` clears the pending request (`req_no` returns to 1). An acknowledge pulse while idle has no effect.
- R7: A read of the data port returns the receive buffer.
- R8: A read of the status port (default address 0xF7) returns the following: bit 0 = request pending, bit 1 = acknowledge asserted (1 while `ack_ni` is held low), bits 2 to 5 = 1, bit 6 = `hsync_i`, bit 7 = `vsync_i`.
- R9: While chip select is high, `spi_miso_oe_o` is 0 and `spi_miso_o` is 0. While chip select is low, `spi_miso_oe_o` is 1.
- R10: `io_rdata_o` is 0xFF when `io_rd_i` is low or when the address matches neither port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| io_addr_i | input | 8 | CPU I/O port address |
| io_wr_i | input | 1 | CPU I/O write strobe, one cycle |
| io_rd_i | input | 1 | CPU I/O read enable |
| io_wdata_i | input | 8 | CPU write data |
| io_rdata_o | output | 8 | CPU read data |
| hsync_i | input | 1 | Horizontal sync level, shown in status |
| vsync_i | input | 1 | Vertical sync level, shown in status |
| req_no | output | 1 | Request to the microcontroller, active low |
| ack_ni | input | 1 | Acknowledge from the microcontroller, active low |
| spi_sck_i | input | 1 | SPI clock from the master |
| spi_mosi_i | input | 1 | SPI data from the master |
| spi_cs_ni | input | 1 | SPI chip select, active low |
| spi_miso_o | output | 1 | SPI data to the master |
| spi_miso_oe_o | output | 1 | Output enable for the MISO pad driver |

## Verification
The assertions check three things on every cycle:
- an accepted write always sets the pending flag;
- a write that arrives while the request is pending never disturbs the latched transmit byte;
- an acknowledge edge always clears the flag.

In the shift logic, the assertions also check that the receive buffer never moves while the slave is deselected, and that the bit counter wraps after the last bit of a frame.

Only the bench scenarios can show the end-to-end bit order on MISO and MOSI, the survival of the old reply after an aborted frame, the status bit layout with the sync inputs, and the full request, transfer, acknowledge and read sequence.

// File: rtl/spi_mbx_pkg.sv
package spi_mbx_pkg;
  localparam int unsigned BYTE_W = 8;
  typedef logic [BYTE_W-1:0] byte_t;
  // constant ones in status bits 2..5
  localparam byte_t STAT_FILL = 8'b0011_1100;
  localparam byte_t RD_IDLE   = 8'hFF;
endpackage

// File: rtl/spi_mbx_sync.sv
module spi_mbx_sync #(
  parameter int unsigned W       = 1,
  parameter int unsigned STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [STAGES-1:0][W-1:0] stg_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stg_q <= {STAGES{RST_VAL}};
        else         stg_q <= d_i;
      end
    end else begin : g_chain
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stg_q <= {STAGES{RST_VAL}};
        else         stg_q <= {stg_q[STAGES-2:0], d_i};
      end
    end
  endgenerate

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/spi_mbx_shift.sv
module spi_mbx_shift #(
  parameter int unsigned DATA_W = 8,
  localparam int unsigned CNT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sck_i,   // synchronized
  input  logic              mosi_i,  // synchronized
  input  logic              cs_ni,   // synchronized
  input  logic [DATA_W-1:0] tx_data_i,
  output logic [DATA_W-1:0] rx_data_o,
  output logic              miso_o,
  output logic              miso_oe_o
);
  logic              sck_q;
  logic              sck_rise, sck_fall;
  logic [CNT_W-1:0]  cnt_q;
  logic [DATA_W-1:0] tx_sh_q, rx_sh_q, rx_buf_q;
  logic [DATA_W-1:0] rx_next;

  assign sck_rise = sck_i & ~sck_q;
  assign sck_fall = ~sck_i & sck_q;
  assign rx_next  = {rx_sh_q[DATA_W-2:0], mosi_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sck_q <= 1'b0;
    else         sck_q <= sck_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q    <= '0;
      tx_sh_q  <= '0;
      rx_sh_q  <= '0;
      rx_buf_q <= '0;
    end else if (cs_ni) begin
      // deselected: realign and preload next outgoing byte
      cnt_q   <= '0;
      tx_sh_q <= tx_data_i;
    end else begin
      if (sck_rise) begin
        rx_sh_q <= rx_next;
        if (cnt_q == CNT_W'(DATA_W-1)) begin
          cnt_q    <= '0;
          rx_buf_q <= rx_next;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
      if (sck_fall) tx_sh_q <= {tx_sh_q[DATA_W-2:0], 1'b0};
    end
  end

  assign miso_o    = cs_ni ? 1'b0 : tx_sh_q[DATA_W-1];
  assign miso_oe_o = ~cs_ni;
  assign rx_data_o = rx_buf_q;

  p_rx_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_ni |=> $stable(rx_buf_q));

  p_cnt_wrap_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cs_ni && sck_rise && cnt_q == CNT_W'(DATA_W-1)) |=> (cnt_q == '0));
endmodule

// File: rtl/spi_mbx.sv
module spi_mbx
  import spi_mbx_pkg::*;
#(
  parameter byte_t       DATA_PORT  = 8'hFB,
  parameter byte_t       STAT_PORT  = 8'hF7,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [7:0] io_addr_i,
  input  logic       io_wr_i,
  input  logic       io_rd_i,
  input  logic [7:0] io_wdata_i,
  output logic [7:0] io_rdata_o,
  input  logic       hsync_i,
  input  logic       vsync_i,
  output logic       req_no,
  input  logic       ack_ni,
  input  logic       spi_sck_i,
  input  logic       spi_mosi_i,
  input  logic       spi_cs_ni,
  output logic       spi_miso_o,
  output logic       spi_miso_oe_o
);
  // sync bundle: [3]=ack_n [2]=cs_n [1]=mosi [0]=sck
  logic [3:0] raw_in, syn_in;
  logic       ack_s, cs_s, mosi_s, sck_s;
  logic       ack_q, ack_fall;
  logic       busy_q, wr_hit, wr_fire;
  byte_t      tx_buf_q, rx_buf, status;

  assign raw_in = {ack_ni, spi_cs_ni, spi_mosi_i, spi_sck_i};

  spi_mbx_sync #(.W(4), .STAGES(SYNC_STAGES), .RST_VAL(4'b1100)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (raw_in),
    .q_o   (syn_in)
  );

  assign {ack_s, cs_s, mosi_s, sck_s} = syn_in;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ack_q <= 1'b1;
    else         ack_q <= ack_s;
  end
  assign ack_fall = ack_q & ~ack_s;

  assign wr_hit  = io_wr_i && (io_addr_i == DATA_PORT);
  assign wr_fire = wr_hit && !busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q   <= 1'b0;
      tx_buf_q <= '0;
    end else if (wr_fire) begin
      busy_q   <= 1'b1;
      tx_buf_q <= io_wdata_i;
    end else if (ack_fall) begin
      busy_q   <= 1'b0;
    end
  end

  assign req_no = ~busy_q;

  spi_mbx_shift #(.DATA_W(BYTE_W)) u_shift (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .sck_i    (sck_s),
    .mosi_i   (mosi_s),
    .cs_ni    (cs_s),
    .tx_data_i(tx_buf_q),
    .rx_data_o(rx_buf),
    .miso_o   (spi_miso_o),
    .miso_oe_o(spi_miso_oe_o)
  );

  always_comb begin
    status    = STAT_FILL;
    status[0] = busy_q;
    status[1] = ~ack_s;
    status[6] = hsync_i;
    status[7] = vsync_i;
  end

  always_comb begin
    io_rdata_o = RD_IDLE;
    if (io_rd_i) begin
      if (io_addr_i == DATA_PORT)      io_rdata_o = rx_buf;
      else if (io_addr_i == STAT_PORT) io_rdata_o = status;
    end
  end

  p_req_set_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_fire |=> (busy_q && !req_no));

  p_busy_wr_ignored_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && wr_hit) |=> $stable(tx_buf_q));

  p_ack_clear_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && ack_fall) |=> !busy_q);
endmodule

// File: tb/tb_spi_mbx.sv
module tb_spi_mbx;
  localparam int CLK_PERIOD = 36;
  localparam int HALF_SCK   = 8;
  localparam logic [7:0] DP = 8'hFB;
  localparam logic [7:0] SP = 8'hF7;
  // {cpu byte, reply byte}
  localparam logic [15:0] VEC [4] = '{16'hA55A, 16'h0F81, 16'hFF00, 16'h3CC3};

  logic       clk = 1'b0, rst_n = 1'b0;
  logic [7:0] addr = 8'h00, wdata = 8'h00, rdata;
  logic       wr = 1'b0, rd = 1'b0;
  logic       hs = 1'b0, vs = 1'b0;
  logic       req_n, ack_n = 1'b1;
  logic       sck = 1'b0, mosi = 1'b0, cs_n = 1'b1, miso, miso_oe;
  int         n_chk = 0, n_fail = 0;
  bit         done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_mbx dut (
    .clk_i(clk), .rst_ni(rst_n), .io_addr_i(addr), .io_wr_i(wr), .io_rd_i(rd),
    .io_wdata_i(wdata), .io_rdata_o(rdata), .hsync_i(hs), .vsync_i(vs),
    .req_no(req_n), .ack_ni(ack_n), .spi_sck_i(sck), .spi_mosi_i(mosi),
    .spi_cs_ni(cs_n), .spi_miso_o(miso), .spi_miso_oe_o(miso_oe)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic cpu_wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr = 1'b1;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic cpu_rd(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; rd = 1'b1;
    #1 d = rdata;
    @(negedge clk); rd = 1'b0;
  endtask

  task automatic ack_pulse();
    @(negedge clk); ack_n = 1'b0;
    wait_clk(4);
    ack_n = 1'b1;
    wait_clk(6);
  endtask

  // one frame of nbits; got holds MISO bits MSB first
  task automatic spi_xfer(input logic [7:0] reply, input int nbits, output logic [7:0] got,
                          output logic oe_seen);
    got = 8'h00;
    @(negedge clk); cs_n = 1'b0;
    wait_clk(HALF_SCK);
    oe_seen = miso_oe;
    for (int i = 0; i < nbits; i++) begin
      got[7-i] = miso;
      mosi = reply[7-i];
      wait_clk(HALF_SCK);
      sck = 1'b1;
      wait_clk(HALF_SCK);
      sck = 1'b0;
      wait_clk(HALF_SCK);
    end
    cs_n = 1'b1; mosi = 1'b0;
    wait_clk(HALF_SCK);
  endtask

  initial begin
    wait_clk(200000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=00 expected=01");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [7:0] d, got;
    logic oe;
    wait_clk(3);
    rst_n = 1'b1;
    wait_clk(2);

    // R1 reset state, R8 status layout, R10 idle read
    check("R1 req_no", {7'd0, req_n}, 8'h01);
    cpu_rd(DP, d); check("R1 rx reset", d, 8'h00);
    cpu_rd(SP, d); check("R1 R8 status idle", d, 8'h3C);
    check("R9 oe idle", {6'd0, miso_oe, miso}, 8'h00);
    #1 check("R10 no read", rdata, 8'hFF);
    cpu_rd(8'h12, d); check("R10 other addr", d, 8'hFF);

    // table walk: R2 R4 R6 R7 R8
    for (int v = 0; v < 4; v++) begin
      cpu_wr(DP, VEC[v][15:8]);
      check("R2 req low", {7'd0, req_n}, 8'h00);
      cpu_rd(SP, d); check("R8 busy bit", d, 8'h3D);
      spi_xfer(VEC[v][7:0], 8, got, oe);
      check("R4 miso byte", got, VEC[v][15:8]);
      check("R9 oe active", {7'd0, oe}, 8'h01);
      ack_pulse();
      check("R6 req cleared", {7'd0, req_n}, 8'h01);
      cpu_rd(DP, d); check("R7 R4 reply", d, VEC[v][7:0]);
    end

    // R8 ack bit and sync bits
    hs = 1'b1;
    @(negedge clk); ack_n = 1'b0;
    wait_clk(3);
    addr = SP; rd = 1'b1; #1 check("R8 ack bit", rdata, 8'h7E);
    wait_clk(1); rd = 1'b0; ack_n = 1'b1;
    wait_clk(6);
    check("R6 ack idle no effect", {7'd0, req_n}, 8'h01);
    hs = 1'b0; vs = 1'b1;
    cpu_rd(SP, d); check("R8 vsync", d, 8'hBC);
    vs = 1'b0;

    // R3 write while busy ignored
    cpu_wr(DP, 8'h11);
    cpu_wr(DP, 8'h22);
    check("R3 still busy", {7'd0, req_n}, 8'h00);
    spi_xfer(8'h99, 8, got, oe);
    check("R3 first byte kept", got, 8'h11);
    ack_pulse();
    cpu_rd(DP, d); check("R7 reply", d, 8'h99);

    // R5 aborted frame keeps old reply
    cpu_wr(DP, 8'h77);
    spi_xfer(8'h5A, 5, got, oe);
    cpu_rd(DP, d); check("R5 partial frame", d, 8'h99);
    check("R5 still busy", {7'd0, req_n}, 8'h00);
    spi_xfer(8'hC6, 8, got, oe);
    check("R4 miso after abort", got, 8'h77);
    ack_pulse();
    cpu_rd(DP, d); check("R5 full frame", d, 8'hC6);
    check("R9 oe after frame", {6'd0, miso_oe, miso}, 8'h00);

    // R1 reset mid-request
    cpu_wr(DP, 8'h33);
    @(negedge clk); rst_n = 1'b0;
    wait_clk(2); rst_n = 1'b1; wait_clk(2);
    check("R1 req after reset", {7'd0, req_n}, 8'h01);
    cpu_rd(DP, d); check("R1 rx after reset", d, 8'h00);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule